// File: doc/BRIEF.md
# I2C Control Register Slave

This block is a two-wire serial slave that lets a microcontroller program eight 8-bit control registers of an audio processor. The master opens a transaction with a START and a chip address byte whose least significant bit selects write (0) or read (1). In a write, the next byte is a subaddress: its low three bits pick the register, and its bit 4 turns on auto-increment. Every following data byte lands in the selected register. Each byte the slave accepts is acknowledged by pulling SDA low during the ninth clock.

In a read, the slave returns a status byte that carries the live soft-mute state. After each master acknowledge the byte is sampled again, so the master can keep reading without sending the address again. SCL and SDA are brought into the system clock through two-flop synchronisers. SDA is driven open-drain through an output enable. The system clock must run at least 8 times faster than the bus bit rate, and bus rates up to 500 kbit/s are supported. The eight registers are presented together on one flat output bus.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: While reset is asserted, all eight registers read 0x00 and the SDA output enable is low.
- R2: A chip address byte whose upper seven bits equal DEV_ADDR (default 7'b1000100, so 0x88 for write and 0x89 for read) is acknowledged: SDA is low during the ninth clock.
- R3: A chip address byte with any other address is not acknowledged. Until the next START, the slave neither acknowledges nor drives SDA, and no register changes.
- R4: Subaddress bits 2..0 select register index i (0 mux-and-gain, 1 mute, 2 left speaker, 3 right speaker, 4..7 high-pass FL, FR, RL, RR). A data byte written to index i appears on regs_o[8*i+7:8*i]. No other register changes.
- R5: With subaddress bit 4 set, each further data byte goes to the next index, and the index wraps from 7 to 0.
- R6: With subaddress bit 4 clear, every data byte of the transaction goes to the same register, and the last byte written remains.
- R7: Once the address matches, the subaddress byte and every data byte are acknowledged.
- R8: In a read, the slave shifts out MSB first a status byte whose bit 2 equals soft_mute_i and whose other bits are 0.
- R9: After each master acknowledge, the status byte is sampled again from soft_mute_i for the next byte. After a master not-acknowledge, the slave releases SDA and stops driving.
- R10: A START at any point, including in the middle of a write without a STOP, restarts the address phase.
- R11: The slave only ever pulls SDA low, and its output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| soft_mute_i | input | 1 | Current soft-mute state, reported in read mode |
| regs_o | output | 64 | Register i on bits 8*i+7 down to 8*i |

## Verification
If the register index is wrong, the data byte shows up in the wrong slice of regs_o one system clock after the acknowledge decision. The scoreboard catches that write as soon as it happens. If the protocol state is wrong, the acknowledge goes missing or appears where none is due, and the master sees it within the same ninth clock. If the auto-increment or wrap logic is wrong, the second or later data byte goes to an unexpected register. A status byte that is loaded at the wrong moment returns the old mute value on the following read byte.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 3;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int MUTE_BIT = 2;
  localparam int AINC_BIT = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } bus_state_t;

  // index step for the next data byte; wraps naturally in IDX_W bits
  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] idx,
                                                  input logic step);
    return step ? idx + 1'b1 : idx;
  endfunction

  // byte returned in read mode
  function automatic logic [BYTE_W-1:0] status_byte(input logic mute);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[MUTE_BIT] = mute;
    return b;
  endfunction
endpackage

// File: rtl/ctlreg_sync.sv
module ctlreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ctlreg_proto.sv
module ctlreg_proto
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_s,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                soft_mute,
  output logic                sda_oe,
  output logic                wr_pulse,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [BYTE_W-1:0]   wr_data,
  output logic                ignoring
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t          state;
  logic [CNT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   shreg, tx;
  logic [IDX_W-1:0]    idx;
  logic                auto_inc, rd_mode, m_nack;
  logic                byte_done;
  logic [BYTE_W-1:0]   stat_now;

  assign byte_done = scl_fall && (bit_cnt == FULL);
  assign stat_now  = status_byte(soft_mute);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      idx      <= '0;
      auto_inc <= 1'b0;
      rd_mode  <= 1'b0;
      m_nack   <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            case (state)
              ST_ADDR: begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                  rd_mode <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              ST_SUB: begin
                idx      <= shreg[IDX_W-1:0];
                auto_inc <= shreg[AINC_BIT];
                sda_oe   <= 1'b1;
                state    <= ST_SUB_ACK;
              end
              default: begin
                sda_oe <= 1'b1;
                state  <= ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              tx     <= stat_now;
              sda_oe <= ~stat_now[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            idx    <= next_index(idx, auto_inc);
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            state   <= ST_RACK;
          end else if (scl_fall) begin
            sda_oe <= ~tx[BYTE_W-2];
            tx     <= {tx[BYTE_W-2:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_nack <= sda_s;
          end else if (scl_fall) begin
            if (!m_nack) begin
              tx     <= stat_now;
              sda_oe <= ~stat_now[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_pulse = (state == ST_WDATA) && byte_done && !start_det && !stop_det;
  assign wr_idx   = idx;
  assign wr_data  = shreg;
  assign ignoring = (state == ST_IGNORE);
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  genvar i;
  generate
    for (i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  r <= '0;
        else if (wr_en && (wr_idx == IDX_W'(i)))     r <= wr_data;
      end
      assign regs_flat[i*BYTE_W +: BYTE_W] = r;
    end
  endgenerate
endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  input  logic                       soft_mute_i,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_pulse, ignoring;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  ctlreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ctlreg_proto #(.DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .soft_mute(soft_mute_i), .sda_oe(sda_oe_o),
    .wr_pulse(wr_pulse), .wr_idx(wr_idx), .wr_data(wr_data),
    .ignoring(ignoring)
  );

  ctlreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse),
    .wr_idx(wr_idx), .wr_data(wr_data), .regs_flat(regs_o)
  );
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
  import ctlreg_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scl_i,
  input logic                       sda_oe_o,
  input logic [NUM_REGS*BYTE_W-1:0] regs_o,
  input logic                       wr_pulse,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [BYTE_W-1:0]          wr_data,
  input logic                       ignoring
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (regs_o == '0 && !sda_oe_o);
    end
  end

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> regs_o[{$past(wr_idx), 3'b000} +: BYTE_W] == $past(wr_data));

  // R4
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(regs_o));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe_o);

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind ctlreg_i2c_slave ctlreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .regs_o(regs_o), .wr_pulse(wr_pulse), .wr_idx(wr_idx),
  .wr_data(wr_data), .ignoring(ignoring)
);

// File: tb/sim_ctlreg_i2c_slave.sv
`timescale 1ns/1ps
module sim_ctlreg_i2c_slave;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic mute = 1'b0;
  logic sda_oe;
  logic [63:0] regs;
  wire  sda_line = !(sda_oe || m_low);

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  model [8];
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  ctlreg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .soft_mute_i(mute), .regs_o(regs)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_wr(input int idx, input logic [7:0] val);
    exp_q.push_back({idx[2:0], val});
    model[idx] = val;
  endtask

  task automatic chk_image(input string req);
    logic [63:0] e;
    for (int i = 0; i < 8; i++) e[i*8 +: 8] = model[i];
    chk(req, regs, e);
  endtask

  // scoreboard monitor: each register change pops one expected write
  initial begin
    logic [63:0] prev;
    logic [10:0] item;
    prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n && regs !== prev) begin
        for (int i = 0; i < 8; i++) begin
          if (regs[i*8 +: 8] !== prev[i*8 +: 8]) begin
            total++;
            if (exp_q.size() == 0) begin
              bad++;
              $display("FAIL R4 unexpected write act=%0d:%h exp=none", i, regs[i*8 +: 8]);
            end else begin
              item = exp_q.pop_front();
              if (item[10:8] != i[2:0] || item[7:0] !== regs[i*8 +: 8]) begin
                bad++;
                $display("FAIL R4 write act=%0d:%h exp=%0d:%h", i, regs[i*8 +: 8],
                         item[10:8], item[7:0]);
              end
            end
          end
        end
        prev = regs;
      end
    end
  end

  task automatic bus_start;
    m_low = 1'b0; waitc(Q);
    scl = 1'b1;   waitc(Q);
    m_low = 1'b1; waitc(Q);
    scl = 1'b0;   waitc(Q);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; waitc(Q);
    scl = 1'b1;   waitc(Q);
    m_low = 1'b0; waitc(2*Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_low = !b; waitc(Q);
    scl = 1'b1; waitc(Q);
    s = sda_line; waitc(Q);
    scl = 1'b0; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack, input logic mute_next);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      v = {v[6:0], s};
    end
    mute = mute_next;
    clk_bit(!mack, s);
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    waitc(5);
    chk("R1 regs at reset", regs, 64'h0);
    chk("R1 sda_oe at reset", {63'h0, sda_oe}, 64'h0);
    rst_n = 1'b1;
    waitc(10);

    // single write, no increment, to index 2
    bus_start;
    send_byte(8'h88, ack); chk("R2 write address ack", {63'h0, ack}, 64'h1);
    send_byte(8'h02, ack); chk("R7 subaddress ack", {63'h0, ack}, 64'h1);
    push_wr(2, 8'h5A);
    send_byte(8'h5A, ack); chk("R7 data ack", {63'h0, ack}, 64'h1);
    bus_stop;
    chk_image("R4 index 2 image");

    // auto-increment from 6 with wrap to 0
    bus_start;
    send_byte(8'h88, ack);
    send_byte(8'h16, ack); chk("R7 subaddress ack inc", {63'h0, ack}, 64'h1);
    push_wr(6, 8'hA1); send_byte(8'hA1, ack);
    push_wr(7, 8'hA2); send_byte(8'hA2, ack);
    push_wr(0, 8'hA3); send_byte(8'hA3, ack);
    chk("R7 third data ack", {63'h0, ack}, 64'h1);
    bus_stop;
    chk_image("R5 increment wraps 7 to 0");

    // no increment: all bytes to index 3
    bus_start;
    send_byte(8'h88, ack);
    send_byte(8'h03, ack);
    push_wr(3, 8'h11); send_byte(8'h11, ack);
    push_wr(3, 8'h22); send_byte(8'h22, ack);
    push_wr(3, 8'h33); send_byte(8'h33, ack);
    bus_stop;
    chk_image("R6 same register");

    // wrong address: ignored until next START
    bus_start;
    send_byte(8'h90, ack); chk("R3 foreign address nack", {63'h0, ack}, 64'h0);
    send_byte(8'h01, ack); chk("R3 no ack while ignoring", {63'h0, ack}, 64'h0);
    send_byte(8'h77, ack); chk("R3 data not acked", {63'h0, ack}, 64'h0);
    bus_stop;
    chk_image("R3 registers untouched");
    bus_start;
    send_byte(8'h88, ack); chk("R3 acks again after START", {63'h0, ack}, 64'h1);
    send_byte(8'h01, ack);
    push_wr(1, 8'h99); send_byte(8'h99, ack);
    bus_stop;
    chk_image("R3 recovery write");

    // repeated START in the middle of a write
    bus_start;
    send_byte(8'h88, ack);
    send_byte(8'h04, ack);
    bus_start;
    send_byte(8'h88, ack); chk("R10 address after repeated START", {63'h0, ack}, 64'h1);
    send_byte(8'h05, ack);
    push_wr(5, 8'h3C); send_byte(8'h3C, ack);
    bus_stop;
    chk_image("R10 write after restart");

    // read: live status refreshed after each master ack
    mute = 1'b1;
    bus_start;
    send_byte(8'h89, ack); chk("R2 read address ack", {63'h0, ack}, 64'h1);
    recv_byte(rd, 1'b1, 1'b0); chk("R8 status mute on", {56'h0, rd}, 64'h04);
    recv_byte(rd, 1'b1, 1'b1); chk("R9 refreshed mute off", {56'h0, rd}, 64'h00);
    recv_byte(rd, 1'b0, 1'b1); chk("R9 refreshed mute on", {56'h0, rd}, 64'h04);
    waitc(Q);
    chk("R9 released after nack", {63'h0, sda_oe}, 64'h0);
    bus_stop;
    chk("R11 idle after stop", {63'h0, sda_oe}, 64'h0);
    chk_image("R8 read leaves registers");

    waitc(20);
    chk("R4 all expected writes seen", exp_q.size(), 64'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule